// File: doc/BRIEF.md
# Packed-Word Palette Write Port

This block holds a 256-entry colour lookup table of 24-bit red/green/blue values and loads it from a host that writes 32-bit words. Each word holds four colour bytes. The bytes are handed out to the red, green and blue components of consecutive entries in a rolling cycle, so a word boundary usually falls inside an entry. Three words complete exactly four entries. A running component phase and entry pointer keep track of where the next byte belongs.

The host first loads a byte-wide address register with the starting entry, which is a multiple of four. It then streams data words. The same address register also selects a small indirect control window. Writing the window at index 4 sets the pixel read mask. A pixel port takes an 8-bit index, ANDs it with the read mask and returns the stored colour one clock later. An entry is written into the table only when its blue byte arrives, so the pixel port never sees an entry that mixes old and new components.

Top module: `pal_packed_wr`

## Requirements
- R1: After reset, every table entry reads as 0x000000, the entry pointer is 0 and the next byte is taken as red.
- R2: An address write loads the address register and the entry pointer with `addr_wdata` and sets the next byte to red. The written value must have its two low bits at zero.
- R3: A data word is consumed most significant byte first (bits 31:24, then 23:16, then 15:8, then 7:0). Its bytes fill red, then green, then blue, then red again, carrying on across words, so three words starting at red fill four entries.
- R4: An entry stays at its old value until its blue byte arrives. The red and green bytes received before that leave the table unchanged.
- R5: After an entry's blue byte is stored, the entry pointer advances by one and wraps from 255 to 0.
- R6: An address write discards any partly assembled entry. The table entry that entry was aimed at keeps its old value.
- R7: When an address write and a data write occur in the same cycle, the address write takes effect and the data word is dropped.
- R8: A control write while the address register holds 4 loads `ctrl_wdata` into the read mask, which resets to 0xFF. A control write while the address register holds any other value leaves the mask unchanged. A control write issued in the same cycle as an address write uses the address register value from before that write.
- R9: `pix_rgb` presents {red, green, blue} of entry (`pix_idx` AND mask) one clock after `pix_idx` is sampled. A lookup in the same cycle as a write to that entry returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | New address register value (starting entry) |
| data_we | input | 1 | Colour data write strobe |
| data_wdata | input | 32 | Four packed colour bytes, most significant first |
| ctrl_we | input | 1 | Control window write strobe |
| ctrl_wdata | input | 8 | Control window write value |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The assertions assume that the host writes only starting addresses that are multiples of four. The stimulus uses only aligned addresses (0, 4, 8, 20, 24, 40, 44, 252). Pointer and phase properties assume that a simultaneous address write overrides the data word. The bench drives that overlap on purpose, and both the assertions and the reference model treat it as an address-only cycle. Strobes change only on the falling clock edge, so every sampled write is a clean single-cycle pulse.

// File: rtl/pal_pkg.sv
package pal_pkg;
   localparam int NCOMP = 3;
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;
endpackage

// File: rtl/pal_lane_split.sv
// Splits one packed word into byte lanes and walks the component phase
// across them; produces up to ceil(LANES/3) entry commits per word.
module pal_lane_split
   import pal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int LANES  = 4
) (
   input  phase_e                                 ph_in,
   input  logic [IDX_W-1:0]                       ptr_in,
   input  logic [COMP_W-1:0]                      r_in,
   input  logic [COMP_W-1:0]                      g_in,
   input  logic [LANES*COMP_W-1:0]                word,
   output phase_e                                 ph_out,
   output logic [IDX_W-1:0]                       ptr_out,
   output logic [COMP_W-1:0]                      r_out,
   output logic [COMP_W-1:0]                      g_out,
   output logic [LANES-1:0]                       commit,
   output logic [LANES-1:0][IDX_W-1:0]            wr_idx,
   output logic [LANES-1:0][NCOMP*COMP_W-1:0]     wr_rgb
);
   localparam int WORD_W = LANES * COMP_W;

   phase_e            ph_c [LANES+1];
   logic [IDX_W-1:0]  pt_c [LANES+1];
   logic [COMP_W-1:0] r_c  [LANES+1];
   logic [COMP_W-1:0] g_c  [LANES+1];

   assign ph_c[0] = ph_in;
   assign pt_c[0] = ptr_in;
   assign r_c[0]  = r_in;
   assign g_c[0]  = g_in;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int HI = WORD_W - 1 - l * COMP_W;
      logic [COMP_W-1:0] lane_byte;
      logic              is_blu;
      assign lane_byte  = word[HI -: COMP_W];
      assign is_blu     = (ph_c[l] == PH_BLU);
      assign ph_c[l+1]  = is_blu ? PH_RED : phase_e'(ph_c[l] + 2'd1);
      assign pt_c[l+1]  = pt_c[l] + {{(IDX_W-1){1'b0}}, is_blu};
      assign r_c[l+1]   = (ph_c[l] == PH_RED) ? lane_byte : r_c[l];
      assign g_c[l+1]   = (ph_c[l] == PH_GRN) ? lane_byte : g_c[l];
      assign commit[l]  = is_blu;
      assign wr_idx[l]  = pt_c[l];
      assign wr_rgb[l]  = {r_c[l], g_c[l], lane_byte};
   end

   assign ph_out  = ph_c[LANES];
   assign ptr_out = pt_c[LANES];
   assign r_out   = r_c[LANES];
   assign g_out   = g_c[LANES];
endmodule

// File: rtl/pal_entry_store.sv
// Colour table: multi-lane write, registered masked read.
module pal_entry_store
   import pal_pkg::*;
#(
   parameter int IDX_W        = 8,
   parameter int COMP_W       = 8,
   parameter int LANES        = 4,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [LANES-1:0]                   commit,
   input  logic [LANES-1:0][IDX_W-1:0]        wr_idx,
   input  logic [LANES-1:0][NCOMP*COMP_W-1:0] wr_rgb,
   input  logic [IDX_W-1:0]                   rd_idx,
   output logic [NCOMP*COMP_W-1:0]            rd_rgb
);
   localparam int DEPTH     = 1 << IDX_W;
   localparam int RGB_W     = NCOMP * COMP_W;
   localparam int MAX_COMMIT = (LANES + NCOMP - 1) / NCOMP;

   logic [RGB_W-1:0] mem [DEPTH];

   if (CLEAR_ON_RST) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (wr_en) begin
            for (int l = 0; l < LANES; l++)
               if (commit[l]) mem[wr_idx[l]] <= wr_rgb[l];
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         if (wr_en) begin
            for (int l = 0; l < LANES; l++)
               if (commit[l]) mem[wr_idx[l]] <= wr_rgb[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_rgb <= '0;
      else        rd_rgb <= mem[rd_idx];
   end

   // R3: a word can never close more entries than its lanes allow
   assert_commit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(commit) <= MAX_COMMIT));
endmodule

// File: rtl/pal_packed_wr.sv
module pal_packed_wr
   import pal_pkg::*;
#(
   parameter int          IDX_W        = 8,
   parameter int          COMP_W       = 8,
   parameter int          LANES        = 4,
   parameter int unsigned MASK_IDX     = 4,
   parameter int unsigned MASK_RST     = 255,
   parameter bit          CLEAR_ON_RST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      addr_we,
   input  logic [IDX_W-1:0]          addr_wdata,
   input  logic                      data_we,
   input  logic [LANES*COMP_W-1:0]   data_wdata,
   input  logic                      ctrl_we,
   input  logic [IDX_W-1:0]          ctrl_wdata,
   input  logic [IDX_W-1:0]          pix_idx,
   output logic [NCOMP*COMP_W-1:0]   pix_rgb
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int RGB_W = NCOMP * COMP_W;

   if (IDX_W < 3 || IDX_W > 12) begin : g_bad_idx
      $error("pal_packed_wr: IDX_W out of range");
   end
   if (LANES < 1 || COMP_W < 1) begin : g_bad_lane
      $error("pal_packed_wr: LANES and COMP_W must be positive");
   end
   if (MASK_IDX >= DEPTH || MASK_RST >= DEPTH) begin : g_bad_mask
      $error("pal_packed_wr: mask index or reset value exceeds index range");
   end

   logic [IDX_W-1:0]  addr_q;
   logic [IDX_W-1:0]  mask_q;
   logic [IDX_W-1:0]  cur_ptr;
   phase_e            cur_ph;
   logic [COMP_W-1:0] part_r;
   logic [COMP_W-1:0] part_g;

   phase_e                           sp_ph;
   logic [IDX_W-1:0]                 sp_ptr;
   logic [COMP_W-1:0]                sp_r;
   logic [COMP_W-1:0]                sp_g;
   logic [LANES-1:0]                 sp_commit;
   logic [LANES-1:0][IDX_W-1:0]      sp_idx;
   logic [LANES-1:0][RGB_W-1:0]      sp_rgb;
   logic                             word_take;

   assign word_take = data_we & ~addr_we;

   pal_lane_split #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)) u_split (
      .ph_in   (cur_ph),
      .ptr_in  (cur_ptr),
      .r_in    (part_r),
      .g_in    (part_g),
      .word    (data_wdata),
      .ph_out  (sp_ph),
      .ptr_out (sp_ptr),
      .r_out   (sp_r),
      .g_out   (sp_g),
      .commit  (sp_commit),
      .wr_idx  (sp_idx),
      .wr_rgb  (sp_rgb)
   );

   pal_entry_store #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES),
                     .CLEAR_ON_RST(CLEAR_ON_RST)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (word_take),
      .commit (sp_commit),
      .wr_idx (sp_idx),
      .wr_rgb (sp_rgb),
      .rd_idx (pix_idx & mask_q),
      .rd_rgb (pix_rgb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         mask_q  <= IDX_W'(MASK_RST);
         cur_ptr <= '0;
         cur_ph  <= PH_RED;
         part_r  <= '0;
         part_g  <= '0;
      end else begin
         if (ctrl_we && addr_q == IDX_W'(MASK_IDX)) mask_q <= ctrl_wdata;
         if (addr_we) begin
            addr_q  <= addr_wdata;
            cur_ptr <= addr_wdata;
            cur_ph  <= PH_RED;
            part_r  <= '0;
            part_g  <= '0;
         end else if (data_we) begin
            cur_ptr <= sp_ptr;
            cur_ph  <= sp_ph;
            part_r  <= sp_r;
            part_g  <= sp_g;
         end
      end
   end

   // R2: host contract, starting entries are multiples of four
   assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_we |-> (addr_wdata[1:0] == 2'b00));

   // R2, R6, R7: address write restarts at red on the written entry
   assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_we |=> (cur_ph == PH_RED && cur_ptr == $past(addr_wdata)));

   // R3: a taken word advances the phase by LANES components
   assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_take |=> (int'(cur_ph) == (int'($past(cur_ph)) + LANES) % NCOMP));

   // R3: phase never leaves the three legal codes
   assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ph != phase_e'(2'd3));

   // R5: pointer advances by completed entries, wrapping modulo depth
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_take |=> (cur_ptr ==
         IDX_W'(int'($past(cur_ptr)) + (int'($past(cur_ph)) + LANES) / NCOMP)));

   // R4: no write strobe, no movement of pointer or phase
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_we && !addr_we) |=> ($stable(cur_ptr) && $stable(cur_ph)));

   // R8: mask changes only through the control window at its index
   assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_we && addr_q == IDX_W'(MASK_IDX)) |=> $stable(mask_q));
endmodule

// File: tb/pal_packed_wr_tb.sv
module pal_packed_wr_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_we = 1'b0;
   logic [7:0]  addr_wdata = '0;
   logic        data_we = 1'b0;
   logic [31:0] data_wdata = '0;
   logic        ctrl_we = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int  n_total = 0;
   int  n_bad   = 0;
   bit  run_cmp = 1'b0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pal_packed_wr u_dut (
      .clk(clk), .rst_n(rst_n),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .data_we(data_we), .data_wdata(data_wdata),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [23:0] act, input logic [23:0] exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   logic [23:0] m_mem [256];
   int          m_ptr, m_ph;
   logic [7:0]  m_r, m_g, m_addr, m_mask, m_b;
   logic [23:0] exp_pix = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) m_mem[i] = '0;
         m_ptr = 0; m_ph = 0; m_r = '0; m_g = '0;
         m_addr = '0; m_mask = 8'hFF; exp_pix = '0;
      end else begin
         exp_pix = m_mem[pix_idx & m_mask];
         if (ctrl_we && m_addr == 8'd4) m_mask = ctrl_wdata;
         if (addr_we) begin
            m_addr = addr_wdata; m_ptr = addr_wdata; m_ph = 0;
         end else if (data_we) begin
            for (int k = 3; k >= 0; k--) begin
               m_b = data_wdata[k*8 +: 8];
               if (m_ph == 0) m_r = m_b;
               else if (m_ph == 1) m_g = m_b;
               else begin
                  m_mem[m_ptr] = {m_r, m_g, m_b};
                  m_ptr = (m_ptr + 1) % 256;
               end
               m_ph = (m_ph + 1) % 3;
            end
         end
      end
   end

   // R9: every cycle the output matches the model's lookup
   always @(negedge clk) begin
      if (run_cmp) check(pix_rgb === exp_pix, "R9 model", pix_rgb, exp_pix);
   end

   // all tasks start and end on a falling edge
   task automatic wr_addr(input logic [7:0] v);
      addr_we = 1'b1; addr_wdata = v;
      @(negedge clk);
      addr_we = 1'b0;
   endtask

   task automatic wr_data(input logic [31:0] v);
      data_we = 1'b1; data_wdata = v;
      @(negedge clk);
      data_we = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic read_chk(input logic [7:0] idx, input logic [23:0] exp,
                           input string tag);
      pix_idx = idx;
      @(negedge clk);
      check(pix_rgb === exp, tag, pix_rgb, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_cmp = 1'b1;

      // R1: table cleared, mask all ones
      read_chk(8'd0,   24'h000000, "R1 entry0 after reset");
      read_chk(8'd200, 24'h000000, "R1 entry200 after reset");

      // R1, R3: pointer at 0, red phase; three words fill four entries
      wr_data(32'h11223344);
      wr_data(32'h55667788);
      wr_data(32'h99AABBCC);
      read_chk(8'd0, 24'h112233, "R3 entry0");
      read_chk(8'd1, 24'h445566, "R3 entry1");
      read_chk(8'd2, 24'h778899, "R3 entry2");
      read_chk(8'd3, 24'hAABBCC, "R3 entry3");

      // R2, R4: partial entries stay invisible until blue arrives
      wr_addr(8'd8);
      wr_data(32'hA1A2A3A4);
      read_chk(8'd8, 24'hA1A2A3, "R2 entry8 from address");
      read_chk(8'd9, 24'h000000, "R4 entry9 red only");
      wr_data(32'hB1B2B3B4);
      read_chk(8'd9,  24'hA4B1B2, "R3 entry9 straddles words");
      read_chk(8'd10, 24'h000000, "R4 entry10 red+green only");
      wr_data(32'hC1C2C3C4);
      read_chk(8'd10, 24'hB3B4C1, "R3 entry10");
      read_chk(8'd11, 24'hC2C3C4, "R3 entry11");

      // R6: address write drops the partial entry
      wr_addr(8'd20);
      wr_data(32'hD1D2D3D4);
      wr_addr(8'd24);
      wr_data(32'hE1E2E3E4);
      read_chk(8'd21, 24'h000000, "R6 entry21 discarded");
      read_chk(8'd24, 24'hE1E2E3, "R6 entry24 restarts at red");

      // R5: wrap from 255 to 0
      wr_addr(8'd252);
      wr_data(32'h01020304);
      wr_data(32'h05060708);
      wr_data(32'h090A0B0C);
      wr_data(32'hF0F1F2F3);
      read_chk(8'd255, 24'h0A0B0C, "R5 entry255");
      read_chk(8'd0,   24'hF0F1F2, "R5 wrapped to entry0");

      // R7: simultaneous address and data, data dropped
      addr_we = 1'b1; addr_wdata = 8'd40;
      data_we = 1'b1; data_wdata = 32'h12345678;
      @(negedge clk);
      addr_we = 1'b0; data_we = 1'b0;
      wr_data(32'h21222324);
      read_chk(8'd40, 24'h212223, "R7 address wins over data");

      // R8: mask loaded through control window at index 4
      wr_addr(8'd4);
      wr_ctrl(8'h0F);
      read_chk(8'hF0, 24'hF0F1F2, "R8 mask 0F maps F0 to entry0");
      read_chk(8'h12, 24'h778899, "R8 mask 0F maps 12 to entry2");
      wr_addr(8'd8);
      wr_ctrl(8'h00);
      read_chk(8'h11, 24'h445566, "R8 control at index 8 ignored");
      wr_addr(8'd4);
      wr_ctrl(8'hFF);
      read_chk(8'hFF, 24'h0A0B0C, "R8 mask restored");

      // R9: lookup in the same cycle as the write returns old data
      wr_addr(8'd44);
      pix_idx = 8'd44;
      data_we = 1'b1; data_wdata = 32'h31323334;
      @(negedge clk);
      data_we = 1'b0;
      check(pix_rgb === 24'h000000, "R9 same-cycle read old", pix_rgb, 24'h000000);
      @(negedge clk);
      check(pix_rgb === 24'h313233, "R9 one-cycle latency", pix_rgb, 24'h313233);

      run_cmp = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_total++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end
endmodule